// File: doc/BRIEF.md
# Stereo Cascaded Biquad Equalizer Engine

This block filters a stereo audio stream through a chain of second-order recursive sections in transposed direct form II. One section is evaluated per clock for both channels at once: the left and right samples see the same coefficient fetch, but each channel keeps its own two delay states per section. The leading feed-forward term of every section is divided out ahead of time. Each section therefore needs only four coefficients, and a single chain gain is applied once to the last section's output.

A sample pair enters through a valid/ready handshake. It visits sections 0 to N-1 on consecutive cycles, is scaled by the gain, and is then offered on a valid/ready output. The coefficients live outside the block. The engine presents a section index and reads the four coefficients of that section in the same cycle. A synchronous clear zeroes every delay state. The output also carries a marker on the last sample of each frame.

Top module: `eq_biquad_chain`

## Requirements
- R1: After reset, in_ready_o is 1, out_valid_o is 0 and every delay state is zero.
- R2: Each active section computes the following on 28-bit signed values, where sat() clips to the 28-bit range and >>> is an arithmetic shift right (rounding toward minus infinity). With input u and states s1 and s2, it forms v = sat(u + s1), new s1 = sat(s2 + ((b1·u − a1·v) >>> 22)) and new s2 = sat((b2·u − a2·v) >>> 22). Coefficients are 24-bit signed Q2.22.
- R3: The input sample is sign-extended to 28 bits and fed to section 0. Each section's v feeds the next section. The output is sat24((gain_i · v_last) >>> 22), where gain_i is Q2.22.
- R4: Both channels use the same coefficients for a section but separate delay states, so one channel's data never changes the other channel's output.
- R5: num_sec_i is sampled when a sample is accepted. A value of 0 acts as 1, and a value above MAX_SEC (16) acts as MAX_SEC. Sections at or above the active count keep their states unchanged.
- R6: out_valid_o rises N rising edges after the edge that accepts the sample, where N is the active section count.
- R7: in_ready_o stays 0 from acceptance until the output handshake. While out_valid_o is 1 and out_ready_i is 0, the output data and valid do not change.
- R8: While clear_i is 1, in_ready_o is 0, and every delay state is zero on the next cycle. The frame position also restarts.
- R9: out_last_o is 1 on every 32nd output sample counted from reset or clear, and 0 otherwise.
- R10: During section k of a sample, coef_idx_o equals k. Sections advance one per cycle starting at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of all delay states and frame position |
| num_sec_i | input | 5 | Requested active section count |
| in_valid_i | input | 1 | Input pair valid |
| in_ready_o | output | 1 | Engine idle and able to accept a pair |
| in_left_i | input | 24 | Left input sample, signed |
| in_right_i | input | 24 | Right input sample, signed |
| out_valid_o | output | 1 | Output pair valid |
| out_ready_i | input | 1 | Downstream accepts output pair |
| out_left_o | output | 24 | Left output sample, signed |
| out_right_o | output | 24 | Right output sample, signed |
| out_last_o | output | 1 | Last sample of a 32-sample frame |
| coef_idx_o | output | 4 | Section whose coefficients are read this cycle |
| coef_b1_i | input | 24 | Normalised b1 of the addressed section, Q2.22 |
| coef_b2_i | input | 24 | Normalised b2 of the addressed section, Q2.22 |
| coef_a1_i | input | 24 | a1 of the addressed section, Q2.22 |
| coef_a2_i | input | 24 | a2 of the addressed section, Q2.22 |
| gain_i | input | 24 | Chain gain (product of all b0), Q2.22 |

## Verification
The assertions assume three things about the coefficient read port and the inputs. The port answers combinationally within the cycle that coef_idx_o is presented. Coefficients, gain and num_sec_i change only while the engine is idle. clear_i is raised only while no sample is in flight. The stimulus respects all three. It rewrites coefficient tables and section counts only after an output handshake, pulses the clear only while waiting for a free engine, and releases out_ready_i only after the hold window under test.

// File: rtl/eq_pkg.sv
package eq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_OUT
  } eq_state_e;

  // clip a signed value to a w-bit two's complement range
  function automatic logic signed [63:0] sat_to(input logic signed [63:0] x, input int w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -(64'sd1 <<< (w - 1));
    if (x > hi) return hi;
    if (x < lo) return lo;
    return x;
  endfunction

endpackage

// File: rtl/eq_sec_math.sv
module eq_sec_math
  import eq_pkg::*;
#(
  parameter int STATE_W = 28,
  parameter int COEF_W  = 24,
  parameter int FRAC    = 22
) (
  input  logic signed [STATE_W-1:0] u_i,
  input  logic signed [STATE_W-1:0] s1_i,
  input  logic signed [STATE_W-1:0] s2_i,
  input  logic signed [COEF_W-1:0]  b1_i,
  input  logic signed [COEF_W-1:0]  b2_i,
  input  logic signed [COEF_W-1:0]  a1_i,
  input  logic signed [COEF_W-1:0]  a2_i,
  output logic signed [STATE_W-1:0] v_o,
  output logic signed [STATE_W-1:0] s1_o,
  output logic signed [STATE_W-1:0] s2_o
);

  logic signed [63:0] u_w, v_w, acc1, acc2, n1, n2;

  always_comb begin
    u_w  = 64'(u_i);
    v_w  = sat_to(u_w + 64'(s1_i), STATE_W);
    acc1 = 64'(b1_i) * u_w - 64'(a1_i) * v_w;
    acc2 = 64'(b2_i) * u_w - 64'(a2_i) * v_w;
    n1   = sat_to(64'(s2_i) + (acc1 >>> FRAC), STATE_W);
    n2   = sat_to(acc2 >>> FRAC, STATE_W);
    v_o  = v_w[STATE_W-1:0];
    s1_o = n1[STATE_W-1:0];
    s2_o = n2[STATE_W-1:0];
  end

endmodule

// File: rtl/eq_state_bank.sv
module eq_state_bank #(
  parameter int STATE_W = 28,
  parameter int MAX_SEC = 16,
  parameter int IDX_W   = 4,
  parameter int NCH     = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clear_i,
  input  logic                          we_i,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic [NCH-1:0][STATE_W-1:0]   wr_s1_i,
  input  logic [NCH-1:0][STATE_W-1:0]   wr_s2_i,
  output logic [NCH-1:0][STATE_W-1:0]   rd_s1_o,
  output logic [NCH-1:0][STATE_W-1:0]   rd_s2_o
);

  logic [STATE_W-1:0] s1_q [NCH][MAX_SEC];
  logic [STATE_W-1:0] s2_q [NCH][MAX_SEC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NCH; c++) begin
        for (int s = 0; s < MAX_SEC; s++) begin
          s1_q[c][s] <= '0;
          s2_q[c][s] <= '0;
        end
      end
    end else if (clear_i) begin
      for (int c = 0; c < NCH; c++) begin
        for (int s = 0; s < MAX_SEC; s++) begin
          s1_q[c][s] <= '0;
          s2_q[c][s] <= '0;
        end
      end
    end else if (we_i) begin
      for (int c = 0; c < NCH; c++) begin
        s1_q[c][idx_i] <= wr_s1_i[c];
        s2_q[c][idx_i] <= wr_s2_i[c];
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      rd_s1_o[c] = s1_q[c][idx_i];
      rd_s2_o[c] = s2_q[c][idx_i];
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (rd_s1_o == '0 && rd_s2_o == '0)); // R8

endmodule

// File: rtl/eq_ctrl.sv
module eq_ctrl
  import eq_pkg::*;
#(
  parameter int MAX_SEC   = 16,
  parameter int FRAME_LEN = 32,
  parameter int IDX_W     = 4,
  parameter int CNT_W     = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] num_sec_i,
  input  logic             in_valid_i,
  input  logic             out_ready_i,
  output logic             in_ready_o,
  output logic             load_o,
  output logic             run_o,
  output logic             last_o,
  output logic [IDX_W-1:0] sec_o,
  output logic             out_valid_o,
  output logic             frame_last_o
);

  localparam int FR_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;

  eq_state_e        st_q;
  logic [CNT_W-1:0] n_q, n_req;
  logic [IDX_W-1:0] sec_q;
  logic [FR_W-1:0]  frm_q;

  always_comb begin
    if (num_sec_i == '0)                       n_req = CNT_W'(1);
    else if (num_sec_i > CNT_W'(MAX_SEC))      n_req = CNT_W'(MAX_SEC);
    else                                       n_req = num_sec_i;
  end

  assign in_ready_o   = (st_q == ST_IDLE) && !clear_i;
  assign load_o       = in_ready_o && in_valid_i;
  assign run_o        = (st_q == ST_RUN);
  assign last_o       = run_o && (CNT_W'(sec_q) == n_q - CNT_W'(1));
  assign sec_o        = sec_q;
  assign out_valid_o  = (st_q == ST_OUT);
  assign frame_last_o = out_valid_o && (frm_q == FR_W'(FRAME_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      n_q   <= CNT_W'(1);
      sec_q <= '0;
      frm_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (load_o) begin
          st_q  <= ST_RUN;
          n_q   <= n_req;
          sec_q <= '0;
        end
        ST_RUN: begin
          if (last_o) st_q  <= ST_OUT;
          else        sec_q <= sec_q + IDX_W'(1);
        end
        ST_OUT: if (out_ready_i) begin
          st_q  <= ST_IDLE;
          frm_q <= (frm_q == FR_W'(FRAME_LEN - 1)) ? '0 : frm_q + FR_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
      if (clear_i) frm_q <= '0;
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> (CNT_W'(sec_q) < n_q)); // R5
  AST_BUSY_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !in_ready_o); // R7
  AST_LAST_TO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> out_valid_o); // R6

endmodule

// File: rtl/eq_biquad_chain.sv
module eq_biquad_chain
  import eq_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int COEF_W    = 24,
  parameter int FRAC      = 22,
  parameter int GUARD     = 4,
  parameter int MAX_SEC   = 16,
  parameter int FRAME_LEN = 32,
  localparam int STATE_W  = DATA_W + GUARD,
  localparam int IDX_W    = (MAX_SEC > 1) ? $clog2(MAX_SEC) : 1,
  localparam int CNT_W    = $clog2(MAX_SEC + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic [CNT_W-1:0]         num_sec_i,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  input  logic signed [DATA_W-1:0] in_left_i,
  input  logic signed [DATA_W-1:0] in_right_i,
  output logic                     out_valid_o,
  input  logic                     out_ready_i,
  output logic signed [DATA_W-1:0] out_left_o,
  output logic signed [DATA_W-1:0] out_right_o,
  output logic                     out_last_o,
  output logic [IDX_W-1:0]         coef_idx_o,
  input  logic signed [COEF_W-1:0] coef_b1_i,
  input  logic signed [COEF_W-1:0] coef_b2_i,
  input  logic signed [COEF_W-1:0] coef_a1_i,
  input  logic signed [COEF_W-1:0] coef_a2_i,
  input  logic signed [COEF_W-1:0] gain_i
);

  localparam int NCH = 2;

  logic load, run, last;
  logic [IDX_W-1:0] sec;

  logic [NCH-1:0][STATE_W-1:0] rd_s1, rd_s2, wr_s1, wr_s2;
  logic signed [STATE_W-1:0] u_q [NCH];
  logic signed [STATE_W-1:0] v_w [NCH];
  logic signed [DATA_W-1:0]  smp_in [NCH];
  logic signed [DATA_W-1:0]  y_n [NCH];
  logic signed [DATA_W-1:0]  y_q [NCH];

  assign smp_in[0] = in_left_i;
  assign smp_in[1] = in_right_i;

  eq_ctrl #(
    .MAX_SEC  (MAX_SEC),
    .FRAME_LEN(FRAME_LEN),
    .IDX_W    (IDX_W),
    .CNT_W    (CNT_W)
  ) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .num_sec_i   (num_sec_i),
    .in_valid_i  (in_valid_i),
    .out_ready_i (out_ready_i),
    .in_ready_o  (in_ready_o),
    .load_o      (load),
    .run_o       (run),
    .last_o      (last),
    .sec_o       (sec),
    .out_valid_o (out_valid_o),
    .frame_last_o(out_last_o)
  );

  eq_state_bank #(
    .STATE_W(STATE_W),
    .MAX_SEC(MAX_SEC),
    .IDX_W  (IDX_W),
    .NCH    (NCH)
  ) i_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .we_i   (run),
    .idx_i  (sec),
    .wr_s1_i(wr_s1),
    .wr_s2_i(wr_s2),
    .rd_s1_o(rd_s1),
    .rd_s2_o(rd_s2)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [STATE_W-1:0] s1_n, s2_n;
    logic signed [63:0] scaled;

    eq_sec_math #(
      .STATE_W(STATE_W),
      .COEF_W (COEF_W),
      .FRAC   (FRAC)
    ) i_math (
      .u_i (u_q[c]),
      .s1_i(rd_s1[c]),
      .s2_i(rd_s2[c]),
      .b1_i(coef_b1_i),
      .b2_i(coef_b2_i),
      .a1_i(coef_a1_i),
      .a2_i(coef_a2_i),
      .v_o (v_w[c]),
      .s1_o(s1_n),
      .s2_o(s2_n)
    );

    assign wr_s1[c] = s1_n;
    assign wr_s2[c] = s2_n;

    // single gain multiply on the last section output
    always_comb begin
      scaled = sat_to((64'(gain_i) * 64'(v_w[c])) >>> FRAC, DATA_W);
      y_n[c] = scaled[DATA_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        u_q[c] <= '0;
        y_q[c] <= '0;
      end else if (load) begin
        u_q[c] <= STATE_W'(smp_in[c]);
      end else if (run) begin
        u_q[c] <= v_w[c];
        if (last) y_q[c] <= y_n[c];
      end
    end
  end

  assign coef_idx_o  = sec;
  assign out_left_o  = y_q[0];
  assign out_right_o = y_q[1];

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_left_o) && $stable(out_right_o))); // R7
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o); // R7

endmodule

// File: tb/test_eq_biquad_chain.sv
`timescale 1ns/1ps
module test_eq_biquad_chain;

  localparam int MAXS = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic clear = 1'b0;
  logic [4:0] num_sec = 5'd1;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic signed [23:0] in_l = '0, in_r = '0;
  logic in_ready, out_valid, out_last;
  logic signed [23:0] out_l, out_r;
  logic [3:0] coef_idx;
  logic signed [23:0] b1m [MAXS];
  logic signed [23:0] b2m [MAXS];
  logic signed [23:0] a1m [MAXS];
  logic signed [23:0] a2m [MAXS];
  logic signed [23:0] gain = 24'sd4194304;

  int errors = 0, checks = 0, out_cnt = 0;
  bit done = 0;
  longint ms1 [2][MAXS];
  longint ms2 [2][MAXS];

  always #2 clk = ~clk;

  eq_biquad_chain i_eq_biquad_chain (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear), .num_sec_i(num_sec),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_left_i(in_l), .in_right_i(in_r),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_left_o(out_l), .out_right_o(out_r),
    .out_last_o(out_last), .coef_idx_o(coef_idx),
    .coef_b1_i(b1m[coef_idx]), .coef_b2_i(b2m[coef_idx]),
    .coef_a1_i(a1m[coef_idx]), .coef_a2_i(a2m[coef_idx]), .gain_i(gain)
  );

  function automatic longint sat(longint x, int w);
    longint hi = (64'sd1 <<< (w - 1)) - 1;
    longint lo = -(64'sd1 <<< (w - 1));
    return (x > hi) ? hi : ((x < lo) ? lo : x);
  endfunction

  function automatic int eff_n();
    if (num_sec == 0) return 1;
    if (num_sec > MAXS) return MAXS;
    return int'(num_sec);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < MAXS; s++) begin ms1[c][s] = 0; ms2[c][s] = 0; end
    out_cnt = 0;
  endtask

  task automatic model(longint l, longint r, output longint yl, output longint yr);
    longint y [2];
    for (int c = 0; c < 2; c++) begin
      longint u = (c == 0) ? l : r;
      for (int s = 0; s < eff_n(); s++) begin
        longint v = sat(u + ms1[c][s], 28);
        longint f1 = longint'(b1m[s]) * u - longint'(a1m[s]) * v;
        longint f2 = longint'(b2m[s]) * u - longint'(a2m[s]) * v;
        ms1[c][s] = sat(ms2[c][s] + (f1 >>> 22), 28);
        ms2[c][s] = sat(f2 >>> 22, 28);
        u = v;
      end
      y[c] = sat((longint'(gain) * u) >>> 22, 24);
    end
    yl = y[0];
    yr = y[1];
  endtask

  // send one pair, hold the output for 'hold' cycles, compare
  task automatic send(longint l, longint r, int hold, string tag);
    longint el, er;
    int cyc;
    int n = eff_n();
    model(l, r, el, er);
    while (!in_ready) @(negedge clk);
    in_l = 24'(l); in_r = 24'(r); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    cyc = 1;
    chk(!in_ready, "R7 busy", longint'(in_ready), 0);
    while (!out_valid && cyc < 40) begin
      chk(coef_idx == 4'(cyc - 1), "R10 idx", longint'(coef_idx), cyc - 1);
      @(negedge clk);
      cyc++;
    end
    chk(cyc == n + 1, "R6 latency", cyc - 1, n);
    for (int h = 0; h < hold; h++) begin
      logic signed [23:0] pl = out_l;
      @(negedge clk);
      chk(out_valid && out_l == pl && !in_ready, "R7 hold", longint'(out_l), longint'(pl));
    end
    chk(longint'(out_l) == el, {tag, " left"}, longint'(out_l), el);
    chk(longint'(out_r) == er, {tag, " right"}, longint'(out_r), er);
    chk(out_last == ((out_cnt % 32) == 31), "R9 frame", longint'(out_last), longint'((out_cnt % 32) == 31));
    out_cnt++;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  function automatic int rnd(int range);
    return int'($urandom_range(0, 2 * range)) - range;
  endfunction

  task automatic rand_coefs();
    for (int s = 0; s < MAXS; s++) begin
      b1m[s] = 24'(rnd(4194304)); b2m[s] = 24'(rnd(2097152));
      a1m[s] = 24'(rnd(4194304)); a2m[s] = 24'(rnd(2097152));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    longint el, er;
    void'($urandom(32'd2718));
    for (int s = 0; s < MAXS; s++) begin b1m[s] = '0; b2m[s] = '0; a1m[s] = '0; a2m[s] = '0; end
    model_clear();
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready", longint'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 valid", longint'(out_valid), 0);

    // zero coefficients, unit gain: pass-through
    num_sec = 5'd3;
    send(1234567, -7654321, 0, "R1 R3 unity");
    send(8388607, -8388608, 0, "R3 unity edge");
    gain = 24'sd2097152;
    send(1000001, -999, 0, "R3 half gain");
    gain = 24'sd4194304;

    // shared coefficients, independent states
    rand_coefs();
    send(3000000, 0, 0, "R4 impulse");
    for (int i = 0; i < 4; i++) begin
      send(0, 0, 0, "R4 tail");
      chk(out_r == 0, "R4 right quiet", longint'(out_r), 0);
    end

    // random run
    num_sec = 5'd4;
    for (int i = 0; i < 30; i++) send(rnd(4194304), rnd(4194304), 0, "R2 random");

    // count clamp
    num_sec = 5'd0;
    for (int i = 0; i < 5; i++) send(rnd(4194304), rnd(4194304), 0, "R5 zero count");
    num_sec = 5'd20;
    for (int i = 0; i < 5; i++) send(rnd(4194304), rnd(4194304), 0, "R5 over count");
    num_sec = 5'd2;
    for (int i = 0; i < 5; i++) send(rnd(4194304), rnd(4194304), 0, "R5 short chain");

    // backpressure
    for (int i = 0; i < 3; i++) send(rnd(4194304), rnd(4194304), 6, "R7 stall");

    // saturating corner
    num_sec = 5'd5;
    for (int s = 0; s < MAXS; s++) begin
      b1m[s] = 24'sh7fffff; b2m[s] = 24'sh7fffff; a1m[s] = 24'sh800000; a2m[s] = 24'sh800000;
    end
    gain = 24'sh7fffff;
    for (int i = 0; i < 6; i++) send((i % 2) ? -8388608 : 8388607, 8388607, 0, "R2 saturate");
    gain = 24'sd4194304;

    // clear
    rand_coefs();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b0, "R8 ready during clear", longint'(in_ready), 0);
    clear = 1'b0;
    model_clear();
    for (int i = 0; i < 8; i++) send(rnd(4194304), rnd(4194304), 0, "R8 after clear");

    // run past two frame boundaries
    num_sec = 5'd16;
    for (int i = 0; i < 60; i++) send(rnd(4194304), rnd(4194304), 0, "R9 long run");
    model(0, 0, el, er);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule